// File: doc/BRIEF.md
# DVMA Page-Table Translation Walker

The walker turns a device virtual address into a physical address by looking up a single-level page table kept in memory. One 32-bit entry covers each 4 KB page. To find the entry, the walker masks off the bits of the address that fall inside the configured window start. It takes the page index relative to the window and adds four times that index to the table base, after the base has been shifted left by four. It fetches the entry through a memory read port that uses a request/response handshake. It then checks the valid bit, and the writable bit when the access is a write. If both checks pass, it reports the translated address. If either fails, it reports a fault and loads a fault status word and a fault address.

A request can span several pages. The walker checks each page in turn. Every page after the first starts at offset zero. The walk stops at the first page that faults, and no further entries are fetched after that. The walker handles one request at a time and drives `busy` while a walk is in progress. Software clears the fault status with a one-cycle strobe.

Top module: `dvma_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `res_valid`, `flt_status` and `flt_addr` are all zero.
- R2: The entry address for a page at address `va` is `(cfg_base << 4) + (((va & ~cfg_win) >> 10) & ~3)`, taken modulo 2^32.
- R3: For a page that does not fault, `res_pa` places entry bits 26:8 at address bits 30:12. Its low 12 bits are the offset of the request for the first page, and zero for every later page.
- R4: An entry whose bit 1 (valid) is 0 faults, for reads and for writes alike.
- R5: A write whose entry has bit 2 (writable) equal to 0 faults. A read of such an entry, with the valid bit set, does not fault.
- R6: Entry bit 7 (cacheable) and entry bit 0 (write-as-zero) change neither `res_pa` nor `res_fault`.
- R7: A fault loads `flt_status` with 0xC0820000 for a write, or 0xC0860000 for a read (bit 18 marks a read). The value is visible one cycle after the faulting result.
- R8: A fault loads `flt_addr` with the failing page address, whose low 12 bits are zero. A newer fault overwrites both registers.
- R9: A request of N pages fetches up to N consecutive entries and gives one `res_valid` pulse per page. `req_pages` = 0 counts as 1. `res_last` marks the final page. The walk stops after the first faulting page.
- R10: `busy` is high from the cycle after a request is accepted until the walk ends. A `req_valid` seen while busy is ignored. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`.
- R11: `sts_clr` zeroes `flt_status` and leaves `flt_addr` unchanged. A fault in the same cycle as `sts_clr` wins.
- R12: A page that does not fault leaves `flt_status` and `flt_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Page table base, before the shift by four |
| cfg_win | input | AW | Window start; its set bits are removed from the address |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_dva | input | AW | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_pages | input | NPW | Number of pages to check (0 means 1) |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_addr | output | AW | Entry address |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry word |
| res_valid | output | 1 | Per-page result strobe |
| res_pa | output | AW | Translated physical address |
| res_fault | output | 1 | Page failed its check |
| res_last | output | 1 | Last result of this request |
| sts_clr | input | 1 | Software clear of the fault status |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | AW | Failing page address |

## Verification
Random addresses are combined with eight window sizes and random table bases. This shows whether the window mask and the index scaling are applied in the right order. Entries whose permission bits are forced or hashed separate the valid check from the write check. The same entries are used for reads and for writes, so a fault that ignores the direction is exposed. Directed multi-page walks, with a fault placed on a chosen page, show whether stepping restarts at offset zero and whether fetching stops at the fault. Clears issued alone and together with a fault settle which of the two takes priority.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_WAIT  = 2'd2,
      WK_CHECK = 2'd3
   } walk_state_e;

   localparam int ENTRY_W     = 32;
   localparam int E_VALID_BIT = 1;
   localparam int E_WRITE_BIT = 2;
   localparam int E_PPN_LO    = 8;
   localparam int E_PPN_HI    = 26;
   localparam int E_PPN_W     = E_PPN_HI - E_PPN_LO + 1;
   localparam int BASE_SHIFT  = 4;

   localparam logic [31:0] FSR_FAULT = 32'hC082_0000;
   localparam logic [31:0] FSR_RDBIT = 32'h0004_0000;
endpackage

// File: rtl/dvma_pte_addr.sv
module dvma_pte_addr #(
   parameter int AW         = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [AW-1:0] tbl_base,
   input  logic [AW-1:0] win_start,
   input  logic [AW-1:0] vaddr,
   output logic [AW-1:0] ent_addr
);
   import dvma_pkg::*;
   localparam int IDX_SHIFT = PAGE_SHIFT - 2;

   logic [AW-1:0] rel_va;
   logic [AW-1:0] idx_off;

   always_comb begin
      rel_va   = vaddr & ~win_start;
      idx_off  = (rel_va >> IDX_SHIFT) & ~AW'(3);
      ent_addr = (tbl_base << BASE_SHIFT) + idx_off;
   end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check #(
   parameter int AW         = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [31:0]   entry,
   input  logic [AW-1:0] vaddr,
   input  logic          is_write,
   output logic [AW-1:0] paddr,
   output logic          fault
);
   import dvma_pkg::*;
   localparam int PA_TOP = PAGE_SHIFT + E_PPN_W;

   generate
      if (AW > PA_TOP) begin : g_pad
         assign paddr = {{(AW-PA_TOP){1'b0}}, entry[E_PPN_HI:E_PPN_LO],
                         vaddr[PAGE_SHIFT-1:0]};
      end else begin : g_exact
         assign paddr = {entry[E_PPN_HI:E_PPN_LO], vaddr[PAGE_SHIFT-1:0]};
      end
   endgenerate

   assign fault = !entry[E_VALID_BIT] || (is_write && !entry[E_WRITE_BIT]);
endmodule

// File: rtl/dvma_fault_regs.sv
module dvma_fault_regs #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          log_fault,
   input  logic          was_read,
   input  logic [AW-1:0] fail_page,
   input  logic          sw_clr,
   output logic [31:0]   status,
   output logic [AW-1:0] fail_addr
);
   import dvma_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status    <= '0;
         fail_addr <= '0;
      end else if (log_fault) begin
         status    <= FSR_FAULT | (was_read ? FSR_RDBIT : 32'd0);
         fail_addr <= fail_page;
      end else if (sw_clr) begin
         status    <= '0;
      end
   end
endmodule

// File: rtl/dvma_walker.sv
module dvma_walker #(
   parameter int AW         = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int NPW        = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  cfg_base,
   input  logic [AW-1:0]  cfg_win,
   input  logic           req_valid,
   input  logic [AW-1:0]  req_dva,
   input  logic           req_write,
   input  logic [NPW-1:0] req_pages,
   output logic           busy,
   output logic           mem_req_valid,
   output logic [AW-1:0]  mem_req_addr,
   input  logic           mem_req_ready,
   input  logic           mem_rsp_valid,
   input  logic [31:0]    mem_rsp_data,
   output logic           res_valid,
   output logic [AW-1:0]  res_pa,
   output logic           res_fault,
   output logic           res_last,
   input  logic           sts_clr,
   output logic [31:0]    flt_status,
   output logic [AW-1:0]  flt_addr
);
   import dvma_pkg::*;

   generate
      if (AW < PAGE_SHIFT + E_PPN_W) begin : g_bad_aw
         $error("dvma_walker: AW too small for the page number field");
      end
      if (PAGE_SHIFT < 4) begin : g_bad_ps
         $error("dvma_walker: PAGE_SHIFT must be at least 4");
      end
      if (NPW < 1) begin : g_bad_npw
         $error("dvma_walker: NPW must be at least 1");
      end
   endgenerate

   walk_state_e    st_q;
   logic [AW-1:0]  cur_va_q;
   logic [NPW-1:0] left_q;
   logic           wr_q;
   logic [31:0]    ent_q;

   logic [AW-1:0]  chk_pa;
   logic           chk_fault;
   logic [AW-1:0]  page_va;
   logic [AW-1:0]  next_va;
   logic           in_check;
   logic           walk_end;

   assign page_va  = (cur_va_q >> PAGE_SHIFT) << PAGE_SHIFT;
   assign next_va  = page_va + (AW'(1) << PAGE_SHIFT);
   assign in_check = (st_q == WK_CHECK);
   assign walk_end = chk_fault || (left_q == '0);

   dvma_pte_addr #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
      .tbl_base (cfg_base),
      .win_start(cfg_win),
      .vaddr    (cur_va_q),
      .ent_addr (mem_req_addr)
   );

   dvma_pte_check #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_check (
      .entry   (ent_q),
      .vaddr   (cur_va_q),
      .is_write(wr_q),
      .paddr   (chk_pa),
      .fault   (chk_fault)
   );

   dvma_fault_regs #(.AW(AW)) u_fregs (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_fault(in_check && chk_fault),
      .was_read (!wr_q),
      .fail_page(page_va),
      .sw_clr   (sts_clr),
      .status   (flt_status),
      .fail_addr(flt_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= WK_IDLE;
         cur_va_q <= '0;
         left_q   <= '0;
         wr_q     <= 1'b0;
         ent_q    <= '0;
      end else begin
         unique case (st_q)
            WK_IDLE: begin
               if (req_valid) begin
                  cur_va_q <= req_dva;
                  wr_q     <= req_write;
                  left_q   <= (req_pages == '0) ? '0 : req_pages - NPW'(1);
                  st_q     <= WK_FETCH;
               end
            end
            WK_FETCH: begin
               if (mem_req_ready) st_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  ent_q <= mem_rsp_data;
                  st_q  <= WK_CHECK;
               end
            end
            WK_CHECK: begin
               if (walk_end) begin
                  st_q <= WK_IDLE;
               end else begin
                  left_q   <= left_q - NPW'(1);
                  cur_va_q <= next_va;
                  st_q     <= WK_FETCH;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign busy          = (st_q != WK_IDLE);
   assign mem_req_valid = (st_q == WK_FETCH);
   assign res_valid     = in_check;
   assign res_fault     = in_check && chk_fault;
   assign res_last      = in_check && walk_end;
   assign res_pa        = chk_pa;
endmodule

// File: rtl/dvma_walker_chk.sv
module dvma_walker_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          mem_req_valid,
   input logic [AW-1:0] mem_req_addr,
   input logic          mem_req_ready,
   input logic          res_valid,
   input logic          res_fault,
   input logic          sts_clr,
   input logic [31:0]   flt_status,
   input logic [AW-1:0] flt_addr
);
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid && !res_valid);

   p_status_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |=> flt_status[31:30] == 2'b11 && flt_status[17]
                                 && flt_status[23:20] == 4'h8);

   p_page_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |=> flt_addr[11:0] == 12'h000);

   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault |=> !busy);

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr && !(res_valid && res_fault) |=> flt_status == 32'd0 && $stable(flt_addr));

   p_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && res_fault) && !sts_clr |=> $stable(flt_status) && $stable(flt_addr));
endmodule

bind dvma_walker dvma_walker_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .mem_req_valid(mem_req_valid),
   .mem_req_addr (mem_req_addr),
   .mem_req_ready(mem_req_ready),
   .res_valid    (res_valid),
   .res_fault    (res_fault),
   .sts_clr      (sts_clr),
   .flt_status   (flt_status),
   .flt_addr     (flt_addr)
);

// File: tb/dvma_walker_test.sv
module dvma_walker_test;
   localparam int AW = 32;
   localparam int NPW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [31:0]    cfg_base = '0, cfg_win = 32'hFF00_0000;
   logic           req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]    req_dva = '0;
   logic [NPW-1:0] req_pages = '0;
   logic           busy, mem_req_valid, mem_req_ready = 1'b0;
   logic [31:0]    mem_req_addr;
   logic           mem_rsp_valid = 1'b0;
   logic [31:0]    mem_rsp_data = '0;
   logic           res_valid, res_fault, res_last;
   logic [31:0]    res_pa;
   logic           sts_clr = 1'b0;
   logic [31:0]    flt_status, flt_addr;

   int checks = 0, errors = 0;
   int hs_count = 0;
   logic [31:0] cap_addr = '0;
   // entry shaping: 0 force clear, 1 force set, 2 from hash
   int vm = 2, wm = 2, xm = 2;
   logic [31:0] key = 32'h1234_5678;
   logic [31:0] bad_ea = 32'hFFFF_FFFF;
   logic [31:0] es = '0, efa = '0;
   bit spur = 0, clr_at_fault = 0;

   always #10 clk = ~clk;

   dvma_walker #(.AW(AW), .PAGE_SHIFT(12), .NPW(NPW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_win(cfg_win),
      .req_valid(req_valid), .req_dva(req_dva), .req_write(req_write),
      .req_pages(req_pages), .busy(busy), .mem_req_valid(mem_req_valid),
      .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_pa(res_pa), .res_fault(res_fault),
      .res_last(res_last), .sts_clr(sts_clr), .flt_status(flt_status),
      .flt_addr(flt_addr));

   function automatic logic [31:0] f_ea(logic [31:0] b, logic [31:0] w, logic [31:0] va);
      return (b << 4) + (((va & ~w) >> 10) & ~32'd3);
   endfunction

   function automatic logic [31:0] f_pa(logic [31:0] e, logic [31:0] va);
      return ((e & 32'h07FF_FF00) << 4) | (va & 32'h0000_0FFF);
   endfunction

   function automatic logic [31:0] pte_of(logic [31:0] a);
      logic [31:0] h;
      h = (a ^ key) * 32'h9E37_79B1;
      h = h ^ (h >> 15);
      if (vm != 2) h[1] = vm[0]; else h[1] = (h[6:4] != 3'd0);
      if (wm != 2) h[2] = wm[0];
      if (xm != 2) begin h[7] = xm[0]; h[0] = xm[0]; end
      if (a == bad_ea) h[1] = 1'b0;
      return h;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // memory responder
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_req_ready = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pte_of(cap_addr);
            end
         end else if (mem_req_valid && ($urandom_range(0, 3) != 0)) begin
            mem_req_ready = 1'b1;
            cap_addr = mem_req_addr;
            hs_count++;
            cnt = 1 + $urandom_range(0, 2);
         end
      end
   end

   task automatic run_req(input logic [31:0] dva, input bit wr, input int pages);
      logic [31:0] va, ea, e, pa_x;
      bit f, lastx;
      int n, hs0;
      n = (pages == 0) ? 1 : pages;
      while (busy) @(negedge clk);
      hs0 = hs_count;
      req_dva = dva; req_write = wr; req_pages = NPW'(pages); req_valid = 1'b1;
      @(negedge clk);
      if (spur) begin
         chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 32'd1);
         req_dva = ~dva; req_write = ~wr;
         @(negedge clk);
      end
      req_valid = 1'b0;
      va = dva;
      for (int p = 0; p < n; p++) begin
         while (!res_valid) @(negedge clk);
         ea = f_ea(cfg_base, cfg_win, va);
         e  = pte_of(ea);
         f  = !e[1] || (wr && !e[2]);
         lastx = f || (p == n - 1);
         pa_x = f_pa(e, va);
         chk(cap_addr == ea, "R2", "entry address", cap_addr, ea);
         chk(res_fault == f, f ? "R4/R5" : "R5", "fault flag", 32'(res_fault), 32'(f));
         if (!f) chk(res_pa == pa_x, "R3", "physical address", res_pa, pa_x);
         chk(res_last == lastx, "R9", "last flag", 32'(res_last), 32'(lastx));
         if (f) begin
            es  = 32'hC082_0000 | (wr ? 32'd0 : 32'h0004_0000);
            efa = va & 32'hFFFF_F000;
            if (clr_at_fault) sts_clr = 1'b1;
         end
         @(posedge clk);
         @(negedge clk);
         sts_clr = 1'b0;
         if (f) begin
            chk(flt_status == es, clr_at_fault ? "R11" : "R7", "fault status", flt_status, es);
            chk(flt_addr == efa, "R8", "fault address", flt_addr, efa);
            break;
         end else begin
            chk(flt_status == es && flt_addr == efa, "R12", "regs kept", flt_status, es);
         end
         va = (va & 32'hFFFF_F000) + 32'h1000;
      end
      chk(busy == 1'b0, "R9", "walk ended", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req_valid, "R9", "no fetch after end", 32'(mem_req_valid), 32'd0);
      chk(hs_count - hs0 <= n, "R9", "fetch count", 32'(hs_count - hs0), 32'(n));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      cfg_base = 32'h0012_3400;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req_valid && !res_valid, "R1", "idle outputs", 32'(busy), 32'd0);
      chk(flt_status == 0 && flt_addr == 0, "R1", "fault regs", flt_status, 32'd0);

      // R5: read of a non-writable valid entry succeeds
      vm = 1; wm = 0; xm = 0;
      run_req(32'hFF01_2345, 1'b0, 1);
      // R5: write of non-writable entry faults, R7 write status
      run_req(32'hFF03_4ABC, 1'b1, 1);
      // R4: invalid entry on a read, R7 read status
      vm = 0; wm = 1;
      run_req(32'hFF05_6777, 1'b0, 1);
      // R11: clear alone
      @(negedge clk); sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
      es = 32'd0;
      chk(flt_status == 32'd0, "R11", "cleared status", flt_status, 32'd0);
      chk(flt_addr == efa, "R11", "address kept", flt_addr, efa);
      // R6: cacheable / write-as-zero bits set
      vm = 1; wm = 1; xm = 1;
      run_req(32'hFF07_0FFF, 1'b1, 1);
      xm = 0;
      run_req(32'hFF07_0FFF, 1'b1, 1);
      // R9: four pages with offset, then page count zero
      run_req(32'hFF10_0804, 1'b0, 4);
      run_req(32'hFF11_0010, 1'b1, 0);
      // R9: fault on the second page stops the walk
      bad_ea = f_ea(cfg_base, cfg_win, 32'hFF20_1000);
      run_req(32'hFF20_0123, 1'b1, 4);
      bad_ea = 32'hFFFF_FFFF;
      // R11: clear coincident with a fault
      vm = 0; clr_at_fault = 1;
      run_req(32'hFF30_0000, 1'b1, 1);
      clr_at_fault = 0;
      // R10: request during busy is ignored
      vm = 1; spur = 1;
      run_req(32'hFF40_0ABC, 1'b0, 2);
      spur = 0;

      // random mix
      vm = 2; wm = 2; xm = 2;
      for (int i = 0; i < 80; i++) begin
         int k;
         k = $urandom_range(0, 7);
         cfg_win  = 32'hFF00_0000 << k;
         cfg_base = $urandom() & 32'h07FF_FC00;
         key      = $urandom();
         spur     = ($urandom_range(0, 5) == 0);
         run_req($urandom(), $urandom_range(0, 1) == 1, $urandom_range(0, 4));
      end
      spur = 0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule